// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of one port of a synchronous memory and produces the address that the port uses for its access in each clock cycle. It can take a new address from the external bus, keep the current address, step it by one for burst transfers, or return it to zero. Three active-low controls select the operation: a clear, an address strobe and a count enable. Their priority is fixed: clear overrides everything, the strobe overrides counting, and counting overrides holding.

The output `addr_o` is the address used for the access in the current cycle. It is combinational, and the internal counter register takes this value at the closing rising edge. As a result, a load, a clear or an increment applies to the access in the same cycle, and no dead cycle is lost. The block has no chip-enable input, so it operates whether or not the port is selected. A synchronous system reset clears the counter. The address width is a parameter, and every step wraps modulo 2^AW.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0. In the first cycle after reset with all controls high, `addr_o` is 0.
- R2: With `clr_n` low, `addr_o` is 0 in that cycle and the counter holds 0 after the edge, whatever `strobe_n`, `cnt_en_n` and `ext_addr` are.
- R3: With `clr_n` high and `strobe_n` low, `addr_o` equals `ext_addr` in that cycle, and that value is stored in the counter.
- R4: With `clr_n` and `strobe_n` high and `cnt_en_n` low, `addr_o` is the stored count plus one, and that value is stored. Consecutive such cycles give consecutive addresses.
- R5: With all three controls high, `addr_o` equals the stored count, the count is unchanged, and `ext_addr` has no effect.
- R6: `cnt_en_n` has no effect while `strobe_n` or `clr_n` is low. No increment is applied on top of a load or a clear.
- R7: An increment from the all-ones address gives 0. Arithmetic is modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous system reset, active high |
| ext_addr | input | AW | External address bus |
| strobe_n | input | 1 | Address strobe, active low: load `ext_addr` |
| cnt_en_n | input | 1 | Count enable, active low: step by one |
| clr_n | input | 1 | Counter clear, active low: go to 0 |
| addr_o | output | AW | Address for the access in this cycle |

## Verification
Each operation shows on `addr_o` in the same cycle as its controls, before the rising edge that stores it. Its effect on the stored count appears one cycle later, as the base for the next hold or increment. The driver applies one control set per falling edge and queues the address it predicts for that cycle. The monitor samples `addr_o` 1 ns after that falling edge, which is 1 ns before the storing edge. Each "ignored" case is therefore confirmed twice: once at once on `addr_o`, and once in the following hold or increment cycle, which exposes the stored count.

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          cnt_en_n,
  input  logic          clr_n,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] cnt_q;

  // Priority: clear, then strobe load, then increment, then hold.
  assign addr_o = !clr_n    ? '0 :
                  !strobe_n ? ext_addr :
                  !cnt_en_n ? cnt_q + AW'(1) :
                              cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= addr_o;
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (cnt_q == '0));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe_n) |=> (cnt_q == $past(ext_addr)));

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && !cnt_en_n) |=> (cnt_q == $past(cnt_q) + AW'(1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && cnt_en_n) |=> $stable(cnt_q));

  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && !cnt_en_n && cnt_q == {AW{1'b1}}) |=> (cnt_q == '0));

endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1, cnt_en_n = 1'b1, clr_n = 1'b1;
  logic [AW-1:0] addr_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [AW-1:0] model = '0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .cnt_en_n(cnt_en_n), .clr_n(clr_n), .addr_o(addr_o));

  task automatic drive(input logic s_n, input logic e_n, input logic c_n,
                       input logic [AW-1:0] a, input string tag);
    logic [AW-1:0] e;
    @(negedge clk);
    rst = 1'b0; strobe_n = s_n; cnt_en_n = e_n; clr_n = c_n; ext_addr = a;
    if (!c_n)      e = '0;
    else if (!s_n) e = a;
    else if (!e_n) e = model + AW'(1);
    else           e = model;
    model = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic sys_reset();
    @(negedge clk);
    rst = 1'b1; strobe_n = 1'b1; cnt_en_n = 1'b1; clr_n = 1'b1;
    model = '0;
  endtask

  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (addr_o !== e) begin
        failures++;
        $display("FAIL %s: addr_o=%h expected=%h", t, addr_o, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    drive(1, 1, 1, 12'h7C1, "R1 zero after reset, ext ignored");
    drive(0, 1, 1, 12'h5A3, "R3 load external");
    drive(1, 0, 1, 12'h111, "R4 step 1");
    drive(1, 0, 1, 12'h222, "R4 step 2");
    drive(1, 0, 1, 12'h333, "R4 step 3");
    drive(1, 1, 1, 12'hABC, "R5 hold ignores ext");
    drive(1, 1, 1, 12'h000, "R5 hold again");
    drive(0, 0, 1, 12'h240, "R6 load with count enable");
    drive(1, 1, 1, 12'h999, "R6 no increment stored on load");
    drive(0, 0, 0, 12'h3FF, "R2 clear overrides strobe and count");
    drive(1, 1, 1, 12'h3FF, "R2 cleared count held");
    drive(1, 0, 1, 12'h000, "R4 step from zero");
    drive(0, 1, 1, 12'hFFF, "R7 load all ones");
    drive(1, 0, 1, 12'h000, "R7 wrap to zero");
    drive(1, 0, 1, 12'h000, "R7 step after wrap");
    drive(0, 1, 1, 12'h080, "R3 load for clear test");
    drive(1, 0, 0, 12'h080, "R6 clear with count enable");
    drive(1, 1, 1, 12'h080, "R6 no increment stored on clear");
    drive(0, 1, 1, 12'h6E6, "R3 load before reset");
    drive(1, 0, 1, 12'h000, "R4 step before reset");
    sys_reset();
    drive(1, 1, 1, 12'h555, "R1 zero after mid-burst reset");
    drive(1, 0, 1, 12'h555, "R1 step from reset value");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule